// File: doc/BRIEF.md
# Linked-Receiver Sample Counter Synchronizer

This block sits in the receive path of one radio front-end that is linked by a cable to one or more other front-ends sharing the same sample clock. One board takes the master role. When the host asks for a sync, that board drives a single-cycle pulse onto a shared I/O line. The other boards take the slave role and watch that line. On every board the pulse becomes a sync event. The event clears a free-running sample counter and resets the phase accumulators and receive buffers downstream. Because every board does this on the same clock edge, their sample streams line up.

For each input sample strobe the block emits a frame, one word per clock. In counting mode, word 0 is the counter value: the upper half goes in the I word and the lower half in the Q word. The enabled data channels follow it. With counting mode off and no role selected, the block is a plain receive path: it emits data words only, and sync has no effect. While receive is not running, the datapath is held in reset.

Top module: `rx_msync_top`

## Requirements
- R1: After reset, `sync_pin_out`, `sync_pin_oe` and `out_valid` are low and `dp_rst` is high.
- R2: In master role with receive running, a `host_sync_wr` sampled at edge t drives `sync_pin_out` high for exactly the one cycle after edge t, after which the request bit clears by itself.
- R3: In slave role, `sync_pin_oe` is low. A high `sync_pin_in` sampled at edge p passes through two synchronizing flops and a rising-edge detector, and `dp_rst` is then high for exactly the one cycle after edge p+2.
- R4: The master delays its own pulse through the same pipeline, so a write at edge t gives a `dp_rst` pulse after edge t+3. A slave sees the master's pin at edge t+1, so its pulse falls in the same cycle.
- R5: A sync event sets the counter to zero, so the first frame taken after the event carries count 0.
- R6: The counter advances by one on each sample strobe taken while receive is running and wraps from all-ones to zero. Each frame carries the value the counter held before that strobe.
- R7: In counting mode (`cfg_count_en`=1), a strobe at edge k produces words in the cycles after edges k, k+1, and so on. Word 0 has tag 0, I = counter upper half and Q = counter lower half. Data channel c (from 0) follows with tag c+1, taking its I and Q from bits [c*W +: W] of `smp_i_in` and `smp_q_in`.
- R8: `cfg_four_ch`=0 enables 2 data channels and `cfg_four_ch`=1 enables 4.
- R9: With `cfg_count_en`=0, frames hold the data words only, tagged 0 upward. With both role bits clear, `sync_pin_oe` stays low and a pulse on `sync_pin_in` raises no `dp_rst`.
- R10: While `rx_run` is low, `dp_rst` is held high, no words are emitted, the counter is held at zero and `host_sync_wr` leaves `sync_pin_out` low.
- R11: In slave role, `host_sync_wr` has no effect: `sync_pin_out` stays low, no `dp_rst` pulse occurs and the counter keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_run | input | 1 | Receive running; low holds the datapath in reset |
| cfg_master | input | 1 | Master role select |
| cfg_slave | input | 1 | Slave role select (master wins if both are set) |
| cfg_count_en | input | 1 | Insert the counter as stream word 0 |
| cfg_four_ch | input | 1 | 0: two data channels, 1: four |
| host_sync_wr | input | 1 | One-cycle host write of the master sync request bit |
| smp_strobe | input | 1 | Sample strobe; captures one frame |
| smp_i_in | input | MAX_DATA_CH*SAMPLE_W | Packed I samples, channel c at [c*W +: W] |
| smp_q_in | input | MAX_DATA_CH*SAMPLE_W | Packed Q samples, same layout |
| sync_pin_in | input | 1 | Shared sync line as received |
| sync_pin_out | output | 1 | Sync line drive value |
| sync_pin_oe | output | 1 | Sync line output enable (master only) |
| dp_rst | output | 1 | Reset to phase accumulators and receive buffers |
| out_valid | output | 1 | Stream word valid |
| out_tag | output | $clog2(MAX_DATA_CH+1) | Channel tag of the stream word |
| out_i | output | SAMPLE_W | Stream word I |
| out_q | output | SAMPLE_W | Stream word Q |

## Verification
The checks assume that `host_sync_wr` is a one-cycle strobe and that role and mode bits change only while no frame is being sent. They also assume that strobes are spaced at least one frame length apart, so a frame is never cut short. The bench sends each strobe only after the previous frame has drained plus a spare cycle. It changes configuration between frames only, and it keeps strobes several cycles clear of any sync event, so the expected counter can be predicted without modelling a strobe and a clear landing on the same edge.

// File: rtl/rx_msync_pkg.sv
package rx_msync_pkg;

    typedef enum logic [1:0] {
        ROLE_NONE   = 2'd0,
        ROLE_MASTER = 2'd1,
        ROLE_SLAVE  = 2'd2
    } sync_role_e;

    // Sync event and datapath reset, as produced together by the detector.
    typedef struct packed {
        logic evt;
        logic dp_rst;
    } sync_ctl_t;

    function automatic sync_role_e pick_role(input logic master, input logic slave);
        if (master)     return ROLE_MASTER;
        else if (slave) return ROLE_SLAVE;
        else            return ROLE_NONE;
    endfunction

    function automatic int unsigned data_ch_count(input logic four, input int unsigned max_ch);
        return (four && max_ch >= 4) ? 4 : 2;
    endfunction

endpackage

// File: rtl/msync_pulse_gen.sv
module msync_pulse_gen
    import rx_msync_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_run,
    input  sync_role_e role,
    input  logic       host_sync_wr,
    output logic       pulse_o
);
    logic req_q;

    // Request bit: set by a host write in master role, cleared one cycle later.
    always_ff @(posedge clk) begin
        if (rst || !rx_run || role != ROLE_MASTER) begin
            req_q <= 1'b0;
        end else if (req_q) begin
            req_q <= 1'b0;
        end else if (host_sync_wr) begin
            req_q <= 1'b1;
        end
    end

    assign pulse_o = req_q;
endmodule

// File: rtl/msync_edge_det.sv
module msync_edge_det
    import rx_msync_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_run,
    input  sync_role_e role,
    input  logic       src_i,
    output sync_ctl_t  ctl_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   active;
    logic                   dp_rst_q;

    assign active = rx_run && (role != ROLE_NONE);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], src_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign ctl_o.evt = active && sync_q[SYNC_STAGES-1] && !prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_rst_q <= 1'b1;
        end else begin
            dp_rst_q <= !rx_run || ctl_o.evt;
        end
    end

    assign ctl_o.dp_rst = dp_rst_q;
endmodule

// File: rtl/msync_counter.sv
module msync_counter #(
    parameter int unsigned COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_run,
    input  logic               clr,
    input  logic               strobe,
    output logic [COUNT_W-1:0] cnt_o
);
    logic [COUNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !rx_run || clr) begin
            cnt_q <= '0;
        end else if (strobe) begin
            cnt_q <= cnt_q + COUNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/msync_framer.sv
module msync_framer
    import rx_msync_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = 16,
    parameter int unsigned MAX_DATA_CH = 4,
    parameter int unsigned TAG_W       = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rx_run,
    input  logic                            count_en,
    input  logic                            four_ch,
    input  logic                            strobe,
    input  logic [2*SAMPLE_W-1:0]           cnt_i,
    input  logic [MAX_DATA_CH*SAMPLE_W-1:0] data_i,
    input  logic [MAX_DATA_CH*SAMPLE_W-1:0] data_q,
    output logic                            out_valid,
    output logic [TAG_W-1:0]                out_tag,
    output logic [SAMPLE_W-1:0]             out_i,
    output logic [SAMPLE_W-1:0]             out_q
);
    localparam int unsigned NSLOT = MAX_DATA_CH + 1;

    logic [SAMPLE_W-1:0] ld_i   [NSLOT];
    logic [SAMPLE_W-1:0] ld_q   [NSLOT];
    logic [SAMPLE_W-1:0] slot_i [NSLOT];
    logic [SAMPLE_W-1:0] slot_q [NSLOT];
    logic                busy_q;
    logic [TAG_W-1:0]    idx_q;
    logic [TAG_W-1:0]    last_q;
    logic [TAG_W-1:0]    last_d;

    // Slot loading: counter in slot 0 when counting, otherwise data from slot 0.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        if (s == 0) begin : g_first
            assign ld_i[s] = count_en ? cnt_i[2*SAMPLE_W-1:SAMPLE_W] : data_i[SAMPLE_W-1:0];
            assign ld_q[s] = count_en ? cnt_i[SAMPLE_W-1:0]          : data_q[SAMPLE_W-1:0];
        end else if (s < MAX_DATA_CH) begin : g_mid
            assign ld_i[s] = count_en ? data_i[(s-1)*SAMPLE_W +: SAMPLE_W] : data_i[s*SAMPLE_W +: SAMPLE_W];
            assign ld_q[s] = count_en ? data_q[(s-1)*SAMPLE_W +: SAMPLE_W] : data_q[s*SAMPLE_W +: SAMPLE_W];
        end else begin : g_tail
            assign ld_i[s] = count_en ? data_i[(s-1)*SAMPLE_W +: SAMPLE_W] : '0;
            assign ld_q[s] = count_en ? data_q[(s-1)*SAMPLE_W +: SAMPLE_W] : '0;
        end
    end

    assign last_d = TAG_W'(data_ch_count(four_ch, MAX_DATA_CH)) - TAG_W'(count_en ? 0 : 1);

    always_ff @(posedge clk) begin
        if (rst || !rx_run) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            last_q <= '0;
        end else if (strobe) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            last_q <= last_d;
        end else if (busy_q) begin
            if (idx_q == last_q) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + TAG_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSLOT; s++) begin
                slot_i[s] <= '0;
                slot_q[s] <= '0;
            end
        end else if (rx_run && strobe) begin
            for (int s = 0; s < NSLOT; s++) begin
                slot_i[s] <= ld_i[s];
                slot_q[s] <= ld_q[s];
            end
        end
    end

    always_comb begin
        out_i = '0;
        out_q = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (idx_q == TAG_W'(s)) begin
                out_i = slot_i[s];
                out_q = slot_q[s];
            end
        end
    end

    assign out_valid = busy_q;
    assign out_tag   = idx_q;
endmodule

// File: rtl/rx_msync_top.sv
module rx_msync_top
    import rx_msync_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = 16,
    parameter int unsigned MAX_DATA_CH = 4,
    localparam int unsigned COUNT_W    = 2 * SAMPLE_W,
    localparam int unsigned TAG_W      = $clog2(MAX_DATA_CH + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rx_run,
    input  logic                            cfg_master,
    input  logic                            cfg_slave,
    input  logic                            cfg_count_en,
    input  logic                            cfg_four_ch,
    input  logic                            host_sync_wr,
    input  logic                            smp_strobe,
    input  logic [MAX_DATA_CH*SAMPLE_W-1:0] smp_i_in,
    input  logic [MAX_DATA_CH*SAMPLE_W-1:0] smp_q_in,
    input  logic                            sync_pin_in,
    output logic                            sync_pin_out,
    output logic                            sync_pin_oe,
    output logic                            dp_rst,
    output logic                            out_valid,
    output logic [TAG_W-1:0]                out_tag,
    output logic [SAMPLE_W-1:0]             out_i,
    output logic [SAMPLE_W-1:0]             out_q
);
    sync_role_e         role;
    logic               pulse;
    logic               sync_src;
    logic               sync_evt;
    sync_ctl_t          ctl;
    logic [COUNT_W-1:0] cnt_q;

    assign role = pick_role(cfg_master, cfg_slave);

    msync_pulse_gen u_pulse (
        .clk          (clk),
        .rst          (rst),
        .rx_run       (rx_run),
        .role         (role),
        .host_sync_wr (host_sync_wr),
        .pulse_o      (pulse)
    );

    // Master feeds its own pulse through the same pipeline a slave uses.
    assign sync_src = (role == ROLE_MASTER) ? pulse : sync_pin_in;

    msync_edge_det #(.SYNC_STAGES(2)) u_det (
        .clk    (clk),
        .rst    (rst),
        .rx_run (rx_run),
        .role   (role),
        .src_i  (sync_src),
        .ctl_o  (ctl)
    );

    assign sync_evt = ctl.evt;
    assign dp_rst   = ctl.dp_rst;

    msync_counter #(.COUNT_W(COUNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .rx_run (rx_run),
        .clr    (sync_evt),
        .strobe (smp_strobe),
        .cnt_o  (cnt_q)
    );

    msync_framer #(
        .SAMPLE_W    (SAMPLE_W),
        .MAX_DATA_CH (MAX_DATA_CH),
        .TAG_W       (TAG_W)
    ) u_frm (
        .clk       (clk),
        .rst       (rst),
        .rx_run    (rx_run),
        .count_en  (cfg_count_en),
        .four_ch   (cfg_four_ch),
        .strobe    (smp_strobe),
        .cnt_i     (cnt_q),
        .data_i    (smp_i_in),
        .data_q    (smp_q_in),
        .out_valid (out_valid),
        .out_tag   (out_tag),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    assign sync_pin_out = pulse;
    assign sync_pin_oe  = (role == ROLE_MASTER);
endmodule

// File: rtl/rx_msync_chk.sv
module rx_msync_chk #(
    parameter int unsigned COUNT_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               rx_run,
    input logic               host_sync_wr,
    input logic               smp_strobe,
    input logic               sync_pin_out,
    input logic               sync_evt,
    input logic               dp_rst,
    input logic               out_valid,
    input logic [COUNT_W-1:0] cnt_q
);
    // R2
    pin_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        sync_pin_out |=> !sync_pin_out);

    // R2
    pin_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_pin_out) |-> $past(host_sync_wr));

    // R5
    evt_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sync_evt |=> (cnt_q == '0));

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_run && smp_strobe && !sync_evt) |=> (cnt_q == COUNT_W'($past(cnt_q) + COUNT_W'(1))));

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_run && !smp_strobe && !sync_evt) |=> $stable(cnt_q));

    // R10
    idle_rst_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_run |=> (dp_rst && !out_valid && cnt_q == '0));

    // R3
    evt_rst_chk: assert property (@(posedge clk) disable iff (rst)
        sync_evt |=> dp_rst);
endmodule

bind rx_msync_top rx_msync_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_run       (rx_run),
    .host_sync_wr (host_sync_wr),
    .smp_strobe   (smp_strobe),
    .sync_pin_out (sync_pin_out),
    .sync_evt     (sync_evt),
    .dp_rst       (dp_rst),
    .out_valid    (out_valid),
    .cnt_q        (cnt_q)
);

// File: tb/rx_msync_top_tb_top.sv
module rx_msync_top_tb_top;
    localparam int SW = 4;
    localparam int NCH = 4;
    localparam int TW = 3;

    typedef struct {
        int    tag;
        int    i;
        int    q;
        string req;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_run = 1'b0;
    logic cfg_master = 1'b0, cfg_slave = 1'b0, cfg_count_en = 1'b0, cfg_four_ch = 1'b0;
    logic host_sync_wr = 1'b0, smp_strobe = 1'b0, sync_pin_in = 1'b0;
    logic [NCH*SW-1:0] smp_i_in = '0, smp_q_in = '0;
    logic sync_pin_out, sync_pin_oe, dp_rst, out_valid;
    logic [TW-1:0] out_tag;
    logic [SW-1:0] out_i, out_q;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_cnt = 0;
    int frame_no = 0;
    bit done = 1'b0;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    rx_msync_top #(.SAMPLE_W(SW), .MAX_DATA_CH(NCH)) dut_i (
        .clk(clk), .rst(rst), .rx_run(rx_run),
        .cfg_master(cfg_master), .cfg_slave(cfg_slave),
        .cfg_count_en(cfg_count_en), .cfg_four_ch(cfg_four_ch),
        .host_sync_wr(host_sync_wr), .smp_strobe(smp_strobe),
        .smp_i_in(smp_i_in), .smp_q_in(smp_q_in),
        .sync_pin_in(sync_pin_in), .sync_pin_out(sync_pin_out),
        .sync_pin_oe(sync_pin_oe), .dp_rst(dp_rst),
        .out_valid(out_valid), .out_tag(out_tag), .out_i(out_i), .out_q(out_q)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: pops expected words as the design emits them.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected stream word tag", int'(out_tag), -1);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk(int'(out_tag) == e.tag && int'(out_i) == e.i && int'(out_q) == e.q,
                    e.req, "stream word (tag*256+i*16+q)",
                    int'(out_tag) * 256 + int'(out_i) * 16 + int'(out_q),
                    e.tag * 256 + e.i * 16 + e.q);
            end
        end
    end

    // Driver: one strobe, expected words pushed to the scoreboard.
    task automatic send_frame(input string req, input bit expect_out);
        int nd;
        int words;
        nd = cfg_four_ch ? 4 : 2;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            smp_i_in[c*SW +: SW] = SW'((frame_no * 3 + c + 1) & 15);
            smp_q_in[c*SW +: SW] = SW'((frame_no * 5 + 2 * c + 7) & 15);
        end
        if (expect_out) begin
            if (cfg_count_en) begin
                exp_q.push_back('{0, (exp_cnt >> 4) & 15, exp_cnt & 15, req});
            end
            for (int c = 0; c < nd; c++) begin
                exp_q.push_back('{c + (cfg_count_en ? 1 : 0),
                                  (frame_no * 3 + c + 1) & 15,
                                  (frame_no * 5 + 2 * c + 7) & 15, req});
            end
            exp_cnt = (exp_cnt + 1) & 8'hFF;
        end
        frame_no++;
        smp_strobe = 1'b1;
        @(negedge clk);
        smp_strobe = 1'b0;
        words = nd + (cfg_count_en ? 1 : 0);
        repeat (words + 1) @(negedge clk);
        chk(exp_q.size() == 0, req, "scoreboard left over after frame", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sync_pin_out == 1'b0, "R1", "pin_out in reset", int'(sync_pin_out), 0);
        chk(sync_pin_oe == 1'b0, "R1", "pin_oe in reset", int'(sync_pin_oe), 0);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(dp_rst == 1'b1, "R1", "dp_rst in reset", int'(dp_rst), 1);
        rst = 1'b0;

        // R10: idle receive ignores sync writes and strobes
        cfg_master = 1'b1; cfg_count_en = 1'b1;
        @(negedge clk); host_sync_wr = 1'b1;
        @(negedge clk); host_sync_wr = 1'b0;
        chk(sync_pin_out == 1'b0, "R10", "pin_out while idle", int'(sync_pin_out), 0);
        @(negedge clk);
        chk(sync_pin_out == 1'b0, "R10", "pin_out while idle later", int'(sync_pin_out), 0);
        chk(dp_rst == 1'b1, "R10", "dp_rst while idle", int'(dp_rst), 1);
        send_frame("R10", 1'b0);

        // R7 counting frames, two channels, counter starts from zero
        rx_run = 1'b1;
        repeat (2) @(negedge clk);
        chk(dp_rst == 1'b0, "R10", "dp_rst released with rx_run", int'(dp_rst), 0);
        exp_cnt = 0;
        for (int f = 0; f < 3; f++) send_frame("R7", 1'b1);

        // R2 / R4 master pulse and aligned reset
        @(negedge clk); host_sync_wr = 1'b1;
        @(negedge clk); host_sync_wr = 1'b0;
        chk(sync_pin_out == 1'b1, "R2", "pin_out cycle after write", int'(sync_pin_out), 1);
        chk(sync_pin_oe == 1'b1, "R2", "pin_oe in master", int'(sync_pin_oe), 1);
        @(negedge clk);
        chk(sync_pin_out == 1'b0, "R2", "pin_out self clear", int'(sync_pin_out), 0);
        chk(dp_rst == 1'b0, "R4", "dp_rst early t+1", int'(dp_rst), 0);
        @(negedge clk);
        chk(dp_rst == 1'b0, "R4", "dp_rst early t+2", int'(dp_rst), 0);
        @(negedge clk);
        chk(dp_rst == 1'b1, "R4", "dp_rst after t+3", int'(dp_rst), 1);
        @(negedge clk);
        chk(dp_rst == 1'b0, "R4", "dp_rst one cycle", int'(dp_rst), 0);
        exp_cnt = 0;
        // R5 and R8: four channels, count restarts at zero
        cfg_four_ch = 1'b1;
        for (int f = 0; f < 3; f++) send_frame("R5", 1'b1);
        send_frame("R8", 1'b1);

        // R9 standard path: no counter word, no sync
        cfg_master = 1'b0; cfg_count_en = 1'b0;
        send_frame("R9", 1'b1);
        cfg_four_ch = 1'b0;
        send_frame("R9", 1'b1);
        chk(sync_pin_oe == 1'b0, "R9", "pin_oe with no role", int'(sync_pin_oe), 0);
        @(negedge clk); sync_pin_in = 1'b1;
        @(negedge clk); sync_pin_in = 1'b0;
        repeat (2) @(negedge clk);
        chk(dp_rst == 1'b0, "R9", "dp_rst with no role", int'(dp_rst), 0);
        repeat (2) @(negedge clk);

        // R3 slave: pin pulse through two flops and edge detect
        cfg_slave = 1'b1; cfg_count_en = 1'b1;
        send_frame("R3", 1'b1);
        chk(sync_pin_oe == 1'b0, "R3", "pin_oe in slave", int'(sync_pin_oe), 0);
        @(negedge clk); sync_pin_in = 1'b1;
        @(negedge clk); sync_pin_in = 1'b0;
        chk(dp_rst == 1'b0, "R3", "dp_rst p+0", int'(dp_rst), 0);
        @(negedge clk);
        chk(dp_rst == 1'b0, "R3", "dp_rst p+1", int'(dp_rst), 0);
        @(negedge clk);
        chk(dp_rst == 1'b1, "R3", "dp_rst after p+2", int'(dp_rst), 1);
        @(negedge clk);
        chk(dp_rst == 1'b0, "R3", "dp_rst one cycle", int'(dp_rst), 0);
        exp_cnt = 0;
        send_frame("R5", 1'b1);
        send_frame("R5", 1'b1);

        // R11 host write ignored in slave role
        @(negedge clk); host_sync_wr = 1'b1;
        @(negedge clk); host_sync_wr = 1'b0;
        chk(sync_pin_out == 1'b0, "R11", "pin_out in slave", int'(sync_pin_out), 0);
        repeat (3) @(negedge clk);
        chk(dp_rst == 1'b0, "R11", "dp_rst in slave after write", int'(dp_rst), 0);
        send_frame("R11", 1'b1);

        // R6 wrap: counter is 8 bits at this width
        for (int f = 0; f < 258; f++) send_frame("R6", 1'b1);

        // R10 rx_run drop clears counter and stream
        rx_run = 1'b0;
        repeat (2) @(negedge clk);
        chk(dp_rst == 1'b1, "R10", "dp_rst after rx_run drop", int'(dp_rst), 1);
        rx_run = 1'b1;
        exp_cnt = 0;
        repeat (2) @(negedge clk);
        send_frame("R10", 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule